// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges the reset causes of a small microcontroller into one system reset. Four sources feed it. The first is an active-low external reset pin. The second is a below-threshold flag from a supply comparator. The third is a one-cycle watchdog overflow pulse. The fourth is a strobe that reports a single-ended-zero condition on the upstream USB port. Each source has its own qualification rule. The external pin must stay low for a minimum time. The supply flag must persist before it counts, and it is then held for a long recovery interval. The USB condition must repeat over several consecutive samples.

The pin, the supply flag and the USB strobe are asynchronous, so each passes through a two-flop synchronizer before it is filtered. The qualified sources are ORed into a single reset. That reset is stretched to a minimum width, so that a single-cycle watchdog pulse still produces a clean reset. A power-on reset (`rst_ni`) asserts the output at once, and the output is always released on a clock edge.

Software sees two enable bits and one status flag. The low-voltage enable is set at power-on. The USB enable is clear at power-on. The USB status flag is sticky and survives the system reset it may have caused.

Top module: `sys_rst_ctrl`

## Requirements
- R1: After `rst_ni` is released, `sys_rst_no` stays low for MIN_W more cycles and then goes high. At that point `lvr_en_o`=1, `usb_en_o`=0 and `usb_flag_o`=0.
- R2: A low level on `ext_rst_ni` that lasts EXT_HOLD consecutive clock cycles asserts the system reset. `sys_rst_no` falls EXT_HOLD+3 edges after the pin falls. A shorter low pulse has no effect.
- R3: A qualified external reset stays asserted while the pin is low. `sys_rst_no` returns high MIN_W+3 edges after the pin's synchronized release.
- R4: `lv_below_i` (active high) must persist LV_FILT consecutive cycles before it resets the system. `sys_rst_no` falls LV_FILT+3 edges after the rise. Shorter excursions are ignored.
- R5: After `lv_below_i` clears, the low-voltage reset stays asserted for LV_STRETCH further cycles before the minimum-width release.
- R6: A configuration write (`cfg_we_i`) loads `cfg_lvr_en_i` into `lvr_en_o`. While `lvr_en_o`=0, `lv_below_i` causes no reset.
- R7: A one-cycle `wdt_ovf_i` pulse makes `sys_rst_no` low from the next edge for exactly MIN_W cycles.
- R8: USB_SE0_CNT consecutive cycles with `usb_se0_i` high (a value from 4 to 8) set `usb_flag_o`, USB_SE0_CNT+3 edges after the first high sample. A shorter run leaves the flag clear.
- R9: When a USB bus reset is detected and `usb_en_o`=1, `sys_rst_no` is low for MIN_W cycles. When `usb_en_o`=0, only the flag is set. A configuration write loads `cfg_usb_en_i` into `usb_en_o`.
- R10: `usb_flag_o` stays set until a `usb_flag_clr_i` pulse clears it on the next edge. A system reset, including one caused by USB, does not clear it.
- R11: `rst_ni` low drives `sys_rst_no` low at once, without a clock, and clears the flag. The release of `sys_rst_no` always happens on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| lv_below_i | input | 1 | Supply below threshold, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse, synchronous |
| usb_se0_i | input | 1 | Single-ended-zero detect on upstream port, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the enable bits |
| cfg_lvr_en_i | input | 1 | Low-voltage reset enable write data |
| cfg_usb_en_i | input | 1 | USB reset enable write data |
| usb_flag_clr_i | input | 1 | Write-one-to-clear strobe for the USB flag |
| lvr_en_o | output | 1 | Low-voltage reset enable |
| usb_en_o | output | 1 | USB reset enable |
| usb_flag_o | output | 1 | Sticky USB bus reset flag |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The bench builds the block with EXT_HOLD=20, LV_FILT=5, LV_STRETCH=40, USB_SE0_CNT=4 and MIN_W=4. At the defaults, the 1 ms hold and the 10 ms stretch would take tens of thousands of cycles. With the small values, each qualification boundary can be reached exactly. This covers a pin pulse one cycle short of the hold, the cycle the low-voltage stretch ends, and the edge where a four-cycle USB run sets the flag. The end of every minimum-width stretch can then be sampled on a known cycle.

// File: rtl/sys_rst_pkg.sv
package sys_rst_pkg;
  typedef struct packed {
    logic usb;
    logic wdt;
    logic lv;
    logic ext;
  } rst_src_t;

  localparam int unsigned SYNC_W = 3;
  localparam int unsigned SYNC_EXT = 0;
  localparam int unsigned SYNC_LV = 1;
  localparam int unsigned SYNC_USB = 2;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/rst_qual_filter.sv
// Qualifies a level after HOLD consecutive active cycles, then keeps it STRETCH cycles past release.
module rst_qual_filter #(
  parameter int unsigned HOLD = 4,
  parameter int unsigned STRETCH = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic qual_o
);
  localparam int unsigned HW = $clog2(HOLD + 1) + 1;
  localparam int unsigned SW = $clog2(STRETCH + 2) + 1;
  localparam logic [HW-1:0] HOLD_M1 = HW'(HOLD - 1);
  localparam logic [HW-1:0] HOLD_C = HW'(HOLD);
  localparam logic [SW-1:0] STR_C = SW'(STRETCH);

  logic [HW-1:0] hold_q;
  logic [SW-1:0] str_q;
  logic qual_q, qual_d;

  always_comb begin
    if (act_i) qual_d = qual_q | (hold_q >= HOLD_M1);
    else       qual_d = qual_q & (str_q < STR_C);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      str_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      qual_q <= qual_d;
      if (act_i) begin
        hold_q <= (hold_q == HOLD_C) ? hold_q : hold_q + 1'b1;
        str_q  <= '0;
      end else begin
        hold_q <= '0;
        str_q  <= (qual_q && str_q < STR_C) ? str_q + 1'b1 : '0;
      end
    end
  end

  assign qual_o = qual_q;

  // R2, R4, R8: qualification only follows an active sample
  p_rise_needs_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_q) |-> $past(act_i));
  // R5: stretch keeps the qualified level while counting
  p_stretch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_q && !act_i && str_q < STR_C) |=> qual_q);
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
  import sys_rst_pkg::*;
#(
  parameter int unsigned EXT_HOLD = 50000,
  parameter int unsigned LV_FILT = 50,
  parameter int unsigned LV_STRETCH = 500000,
  parameter int unsigned USB_SE0_CNT = 4,
  parameter int unsigned MIN_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic lv_below_i,
  input  logic wdt_ovf_i,
  input  logic usb_se0_i,
  input  logic cfg_we_i,
  input  logic cfg_lvr_en_i,
  input  logic cfg_usb_en_i,
  input  logic usb_flag_clr_i,
  output logic lvr_en_o,
  output logic usb_en_o,
  output logic usb_flag_o,
  output logic sys_rst_no
);
  localparam int unsigned MW = $clog2(MIN_W + 1) + 1;
  localparam logic [MW-1:0] MIN_W_M1 = MW'(MIN_W - 1);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << SYNC_EXT;

  logic [SYNC_W-1:0] async_in, sync_out;
  logic ext_q, lv_q, usb_q, usb_q_d, usb_evt;
  logic lvr_en_q, usb_en_q, usb_flag_q;
  logic rst_act_q;
  logic [MW-1:0] wid_q;
  rst_src_t src, src_en;
  logic rst_any;

  always_comb begin
    async_in = '0;
    async_in[SYNC_EXT] = ext_rst_ni;
    async_in[SYNC_LV]  = lv_below_i;
    async_in[SYNC_USB] = usb_se0_i;
  end

  rst_sync2 #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(async_in), .q_o(sync_out)
  );

  rst_qual_filter #(.HOLD(EXT_HOLD), .STRETCH(0)) i_ext_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(~sync_out[SYNC_EXT]), .qual_o(ext_q)
  );

  // not gated by any core sleep state
  rst_qual_filter #(.HOLD(LV_FILT), .STRETCH(LV_STRETCH)) i_lv_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(sync_out[SYNC_LV]), .qual_o(lv_q)
  );

  rst_qual_filter #(.HOLD(USB_SE0_CNT), .STRETCH(0)) i_usb_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(sync_out[SYNC_USB]), .qual_o(usb_q)
  );

  assign usb_evt = usb_q & ~usb_q_d;

  // control bits only see power-on reset, never the system reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvr_en_q   <= 1'b1;
      usb_en_q   <= 1'b0;
      usb_flag_q <= 1'b0;
      usb_q_d    <= 1'b0;
    end else begin
      usb_q_d <= usb_q;
      if (cfg_we_i) begin
        lvr_en_q <= cfg_lvr_en_i;
        usb_en_q <= cfg_usb_en_i;
      end
      if (usb_evt)             usb_flag_q <= 1'b1;
      else if (usb_flag_clr_i) usb_flag_q <= 1'b0;
    end
  end

  always_comb begin
    src.ext = ext_q;
    src.lv  = lv_q;
    src.wdt = wdt_ovf_i;
    src.usb = usb_evt;
    src_en  = '{usb: usb_en_q, wdt: 1'b1, lv: lvr_en_q, ext: 1'b1};
  end

  assign rst_any = |(src & src_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_act_q <= 1'b1;
      wid_q     <= MIN_W_M1;
    end else begin
      rst_act_q <= rst_any || (wid_q != '0);
      if (rst_any)          wid_q <= MIN_W_M1;
      else if (wid_q != '0) wid_q <= wid_q - 1'b1;
    end
  end

  assign sys_rst_no = ~rst_act_q;
  assign lvr_en_o   = lvr_en_q;
  assign usb_en_o   = usb_en_q;
  assign usb_flag_o = usb_flag_q;

  p_wdt_to_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ovf_i |=> !sys_rst_no);
  p_min_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_act_q) |=> rst_act_q);
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_flag_q && !usb_flag_clr_i) |=> usb_flag_q);
  p_cfg_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (lvr_en_o == $past(cfg_lvr_en_i)));
  p_usb_dis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_act_q && !ext_q && !(lv_q && lvr_en_q) && !wdt_ovf_i && !usb_en_q) |=> !rst_act_q);
endmodule

// File: tb/test_sys_rst_ctrl.sv
module test_sys_rst_ctrl;
  localparam int EXT_HOLD = 20;
  localparam int LV_FILT = 5;
  localparam int LV_STRETCH = 40;
  localparam int USB_CNT = 4;
  localparam int MIN_W = 4;

  localparam int S_RST = 0;
  localparam int S_FLAG = 1;
  localparam int S_LVR = 2;
  localparam int S_USB = 3;

  typedef struct {
    int    cyc;
    int    sig;
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst_ni = 1'b1, lv_below_i = 1'b0, wdt_ovf_i = 1'b0, usb_se0_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_lvr_en_i = 1'b1, cfg_usb_en_i = 1'b0, usb_flag_clr_i = 1'b0;
  logic lvr_en_o, usb_en_o, usb_flag_o, sys_rst_no;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sys_rst_ctrl #(
    .EXT_HOLD(EXT_HOLD), .LV_FILT(LV_FILT), .LV_STRETCH(LV_STRETCH),
    .USB_SE0_CNT(USB_CNT), .MIN_W(MIN_W)
  ) i_sys_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .lv_below_i(lv_below_i),
    .wdt_ovf_i(wdt_ovf_i), .usb_se0_i(usb_se0_i), .cfg_we_i(cfg_we_i),
    .cfg_lvr_en_i(cfg_lvr_en_i), .cfg_usb_en_i(cfg_usb_en_i),
    .usb_flag_clr_i(usb_flag_clr_i), .lvr_en_o(lvr_en_o), .usb_en_o(usb_en_o),
    .usb_flag_o(usb_flag_o), .sys_rst_no(sys_rst_no)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int dly, input int sig, input logic exp, input string req);
    item_t it;
    it.cyc = cyc + dly;
    it.sig = sig;
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    tick(2);
  endtask

  task automatic cfg_write(input logic lvr, input logic usb);
    push(1, S_LVR, lvr, "R6");
    push(1, S_USB, usb, "R9");
    cfg_lvr_en_i = lvr;
    cfg_usb_en_i = usb;
    cfg_we_i = 1'b1;
    tick(1);
    cfg_we_i = 1'b0;
    drain();
  endtask

  // monitor: pops expected items at their cycle, sampled at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      logic act;
      it = sb.pop_front();
      case (it.sig)
        S_RST:   act = sys_rst_no;
        S_FLAG:  act = usb_flag_o;
        S_LVR:   act = lvr_en_o;
        default: act = usb_en_o;
      endcase
      check(it.req, act, it.exp);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3);
    check("R11", sys_rst_no, 1'b0);
    // R1 power-on release
    push(MIN_W - 1, S_RST, 1'b0, "R1");
    push(MIN_W, S_RST, 1'b1, "R1");
    push(MIN_W, S_LVR, 1'b1, "R1");
    push(MIN_W, S_USB, 1'b0, "R1");
    push(MIN_W, S_FLAG, 1'b0, "R1");
    rst_ni = 1'b1;
    drain();

    // R2/R3 qualified external reset, pin low 30 cycles
    push(10, S_RST, 1'b1, "R2");
    push(EXT_HOLD + 2, S_RST, 1'b1, "R2");
    push(EXT_HOLD + 3, S_RST, 1'b0, "R2");
    push(30 + 6, S_RST, 1'b0, "R3");
    push(30 + 7, S_RST, 1'b1, "R3");
    ext_rst_ni = 1'b0;
    tick(30);
    ext_rst_ni = 1'b1;
    drain();

    // R2 pulse one cycle short of the hold
    push(10, S_RST, 1'b1, "R2");
    push(EXT_HOLD + 3, S_RST, 1'b1, "R2");
    push(EXT_HOLD + 6, S_RST, 1'b1, "R2");
    ext_rst_ni = 1'b0;
    tick(EXT_HOLD - 1);
    ext_rst_ni = 1'b1;
    drain();

    // R4/R5 low-voltage 20 cycles
    push(LV_FILT + 2, S_RST, 1'b1, "R4");
    push(LV_FILT + 3, S_RST, 1'b0, "R4");
    push(20 + LV_STRETCH + 6, S_RST, 1'b0, "R5");
    push(20 + LV_STRETCH + 7, S_RST, 1'b1, "R5");
    lv_below_i = 1'b1;
    tick(20);
    lv_below_i = 1'b0;
    drain();

    // R4 short excursion
    push(LV_FILT + 3, S_RST, 1'b1, "R4");
    push(LV_FILT + 8, S_RST, 1'b1, "R4");
    lv_below_i = 1'b1;
    tick(LV_FILT - 1);
    lv_below_i = 1'b0;
    drain();

    // R6 disable low-voltage source
    cfg_write(1'b0, 1'b0);
    push(LV_FILT + 3, S_RST, 1'b1, "R6");
    push(30, S_RST, 1'b1, "R6");
    push(80, S_RST, 1'b1, "R6");
    lv_below_i = 1'b1;
    tick(20);
    lv_below_i = 1'b0;
    drain();
    cfg_write(1'b1, 1'b0);

    // R7 watchdog pulse
    for (int i = 1; i <= MIN_W; i++) push(i, S_RST, 1'b0, "R7");
    push(MIN_W + 1, S_RST, 1'b1, "R7");
    wdt_ovf_i = 1'b1;
    tick(1);
    wdt_ovf_i = 1'b0;
    drain();

    // R8/R9 USB reset with enable clear: flag only
    push(USB_CNT + 2, S_FLAG, 1'b0, "R8");
    push(USB_CNT + 3, S_FLAG, 1'b1, "R8");
    push(USB_CNT + 3, S_RST, 1'b1, "R9");
    push(USB_CNT + 6, S_RST, 1'b1, "R9");
    usb_se0_i = 1'b1;
    tick(6);
    usb_se0_i = 1'b0;
    drain();

    // R10 flag sticky, then cleared
    push(5, S_FLAG, 1'b1, "R10");
    tick(5);
    push(1, S_FLAG, 1'b0, "R10");
    usb_flag_clr_i = 1'b1;
    tick(1);
    usb_flag_clr_i = 1'b0;
    drain();

    // R8 short run
    push(USB_CNT + 3, S_FLAG, 1'b0, "R8");
    push(USB_CNT + 6, S_FLAG, 1'b0, "R8");
    usb_se0_i = 1'b1;
    tick(USB_CNT - 1);
    usb_se0_i = 1'b0;
    drain();

    // R9/R10 USB reset with enable set; flag survives the reset
    cfg_write(1'b1, 1'b1);
    push(USB_CNT + 2, S_RST, 1'b1, "R9");
    push(USB_CNT + 3, S_RST, 1'b0, "R9");
    push(USB_CNT + 3, S_FLAG, 1'b1, "R9");
    push(USB_CNT + 2 + MIN_W, S_RST, 1'b0, "R9");
    push(USB_CNT + 3 + MIN_W, S_RST, 1'b1, "R9");
    push(USB_CNT + 4 + MIN_W, S_FLAG, 1'b1, "R10");
    usb_se0_i = 1'b1;
    tick(6);
    usb_se0_i = 1'b0;
    drain();

    // R11 asynchronous assertion from power-on reset
    rst_ni = 1'b0;
    #1;
    check("R11", sys_rst_no, 1'b0);
    check("R11", usb_flag_o, 1'b0);
    tick(2);
    push(MIN_W - 1, S_RST, 1'b0, "R11");
    push(MIN_W, S_RST, 1'b1, "R11");
    rst_ni = 1'b1;
    drain();

    finish_run();
  end
endmodule